// File: doc/BRIEF.md
# Timer-Driven Configuration Sequencer

This block is the control core of a very low-power sensing node. It has no instruction stream. All activity begins when one of a bank of countdown timers runs out. The expiring timer selects a starting entry in a small setup memory. The word stored there is driven straight onto the control lines of a separate datapath, for example power enables, multiplexer selects and write strobes. When the datapath signals that the step has finished, the sequencer moves to the entry that the word names as its successor. A word flagged as the final step ends the task. Between tasks the block only counts, and its control output stays all zeros, so every datapath unit is left unpowered.

Each timer holds two reload values, a normal one and an alternate one, and a per-timer rate bit chooses between them. This lets software, or the datapath's own results, make sampling faster after an event of interest and slower again afterwards. The setup memory is split into banks. An operating-mode input chooses the bank when a task starts, so the same timers can run cheaper or richer step lists depending on the energy that is available.

Top module: `timer_cfg_seq`

## Requirements
- R1: After reset, cfg_valid is 0 and cfg_ctrl is all zeros, and every reload value, rate bit and counter is zero. A timer whose selected reload value is zero never expires, so no task can start until a non-zero reload value is written.
- R2: A timer whose selected reload value R is non-zero counts down by one each cycle. In the cycle its counter is zero it expires and loads R in that same cycle, so expiries repeat every R+1 cycles. A timer whose counter is zero when its reload value becomes non-zero expires in the first cycle after the write. A write with tmr_wr_alt=0 sets the normal value and a write with tmr_wr_alt=1 sets the alternate value.
- R3: A rate bit of 1 makes the timer reload from its alternate value and a rate bit of 0 makes it reload from its normal value. A rate change takes effect at the timer's next reload.
- R4: An expiry of timer i becomes pending at the clock edge that ends the expiry cycle. An idle sequencer starts its chosen pending timer at the next edge, so cfg_valid is high from the second edge after the expiry cycle. The task begins at entry index i of the bank given by mode_sel as sampled at that start edge.
- R5: While a task is active, cfg_valid is 1 and cfg_ctrl equals the 24-bit control field of the current entry. Each setup word holds a control field, a 3-bit next index and a last flag. At an edge with step_done high, a word with last=1 ends the task and a word with last=0 moves to its next index. Without step_done the entry does not change.
- R6: Whenever no task is active, cfg_ctrl is all zeros.
- R7: When several timers are pending as a task is about to start, the lowest-numbered one is served first.
- R8: An expiry that occurs while a task is active, or while that timer is already pending, is kept pending and served after the running task ends. Repeated expiries of one timer before it is served merge into a single pending task.
- R9: step_done has no effect while no task is active.
- R10: A change of mode_sel during a task does not alter the bank that the task reads from.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tmr_wr_en | input | 1 | Write a timer reload value |
| tmr_wr_sel | input | 2 | Timer addressed by the reload write |
| tmr_wr_alt | input | 1 | 0 writes the normal value, 1 writes the alternate value |
| tmr_wr_val | input | 16 | Reload value to write |
| rate_wr_en | input | 1 | Write a timer rate bit |
| rate_wr_sel | input | 2 | Timer addressed by the rate write |
| rate_wr_val | input | 1 | New rate bit (1 selects the alternate value) |
| su_wr_en | input | 1 | Write a setup memory word |
| su_wr_bank | input | 1 | Bank of the setup write |
| su_wr_idx | input | 3 | Entry index of the setup write |
| su_wr_ctrl | input | 24 | Control field to store |
| su_wr_next | input | 3 | Next-entry index to store |
| su_wr_last | input | 1 | Last-step flag to store |
| mode_sel | input | 1 | Operating mode, which selects the setup bank for new tasks |
| step_done | input | 1 | Datapath reports that the current step is finished |
| cfg_ctrl | output | 24 | Datapath control lines, all zeros when idle |
| cfg_valid | output | 1 | High while a task is active |

## Verification
The assertions check on every cycle that the control output is zero whenever no task is active and that an active step holds until done arrives. They also check that each expiry leaves its timer pending, that a task begins only from a pending timer, that the lowest-numbered pending timer wins, and that an idle sequencer with nothing pending stays idle whatever step_done does. The bench's scenarios are needed for the timing of the two reload rates, for the exact cycle in which a task starts after an expiry, for the walk along the next-index chain, for the merging of repeated expiries, and for the bank staying fixed while mode_sel changes mid-task. A cycle-accurate model in the bench follows all of these.

// File: rtl/seq_pkg.sv
package seq_pkg;

    localparam int NUM_TMR  = 4;
    localparam int CNT_W    = 16;
    localparam int CTRL_W   = 24;
    localparam int IDX_W    = 3;
    localparam int NUM_BANK = 2;

    localparam int TMR_W  = $clog2(NUM_TMR);
    localparam int BANK_W = (NUM_BANK > 1) ? $clog2(NUM_BANK) : 1;
    localparam int DEPTH  = 1 << IDX_W;

    typedef struct packed {
        logic              last;
        logic [IDX_W-1:0]  nxt;
        logic [CTRL_W-1:0] ctrl;
    } setup_word_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } seq_state_e;

    function automatic logic [TMR_W-1:0] lowest_pending(input logic [NUM_TMR-1:0] v);
        logic [TMR_W-1:0] r;
        r = '0;
        for (int k = NUM_TMR - 1; k >= 0; k--) begin
            if (v[k]) r = TMR_W'(k);
        end
        return r;
    endfunction

endpackage

// File: rtl/seq_timer.sv
module seq_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             wr_alt,
    input  logic [CNT_W-1:0] wr_val,
    input  logic             rate_wr_en,
    input  logic             rate_val,
    output logic             expire
);

    logic [CNT_W-1:0] norm_q, alt_q, cnt_q, sel_val;
    logic             rate_q;

    always_comb begin
        sel_val = rate_q ? alt_q : norm_q;
        expire  = (cnt_q == '0) && (sel_val != '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            norm_q <= '0;
            alt_q  <= '0;
            cnt_q  <= '0;
            rate_q <= 1'b0;
        end else begin
            if (expire)
                cnt_q <= sel_val;
            else if (cnt_q != '0)
                cnt_q <= cnt_q - CNT_W'(1);
            if (wr_en) begin
                if (wr_alt) alt_q  <= wr_val;
                else        norm_q <= wr_val;
            end
            if (rate_wr_en)
                rate_q <= rate_val;
        end
    end

endmodule

// File: rtl/seq_setup_mem.sv
module seq_setup_mem
    import seq_pkg::*;
#(
    parameter int NB = NUM_BANK,
    parameter int BW = BANK_W,
    parameter int IW = IDX_W
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [BW-1:0] wr_bank,
    input  logic [IW-1:0] wr_idx,
    input  setup_word_t   wr_word,
    input  logic [BW-1:0] rd_bank,
    input  logic [IW-1:0] rd_idx,
    output setup_word_t   rd_word
);

    localparam int ND = 1 << IW;

    setup_word_t mem [NB][ND];

    always_ff @(posedge clk) begin
        if (wr_en)
            mem[wr_bank][wr_idx] <= wr_word;
    end

    assign rd_word = mem[rd_bank][rd_idx];

endmodule

// File: rtl/seq_core.sv
module seq_core
    import seq_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_TMR-1:0] expire,
    input  logic [BANK_W-1:0]  mode_sel,
    input  logic               step_done,
    input  setup_word_t        rd_word,
    output logic [BANK_W-1:0]  rd_bank,
    output logic [IDX_W-1:0]   rd_idx,
    output logic [CTRL_W-1:0]  cfg_ctrl,
    output logic               cfg_valid,
    output logic [NUM_TMR-1:0] pend,
    output logic               start,
    output logic [TMR_W-1:0]   grant
);

    seq_state_e          state_q;
    logic [IDX_W-1:0]    idx_q;
    logic [BANK_W-1:0]   bank_q;
    logic [NUM_TMR-1:0]  pend_q, clr;

    always_comb begin
        start     = (state_q == ST_IDLE) && (pend_q != '0);
        grant     = lowest_pending(pend_q);
        clr       = start ? (NUM_TMR'(1) << grant) : '0;
        pend      = pend_q;
        rd_bank   = bank_q;
        rd_idx    = idx_q;
        cfg_valid = (state_q == ST_RUN);
        cfg_ctrl  = cfg_valid ? rd_word.ctrl : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            bank_q  <= '0;
            pend_q  <= '0;
        end else begin
            pend_q <= (pend_q & ~clr) | expire;
            if (start) begin
                state_q <= ST_RUN;
                idx_q   <= IDX_W'(grant);
                bank_q  <= mode_sel;
            end else if (state_q == ST_RUN && step_done) begin
                if (rd_word.last) state_q <= ST_IDLE;
                else              idx_q   <= rd_word.nxt;
            end
        end
    end

endmodule

// File: rtl/timer_cfg_seq.sv
module timer_cfg_seq
    import seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tmr_wr_en,
    input  logic [TMR_W-1:0]  tmr_wr_sel,
    input  logic              tmr_wr_alt,
    input  logic [CNT_W-1:0]  tmr_wr_val,
    input  logic              rate_wr_en,
    input  logic [TMR_W-1:0]  rate_wr_sel,
    input  logic              rate_wr_val,
    input  logic              su_wr_en,
    input  logic [BANK_W-1:0] su_wr_bank,
    input  logic [IDX_W-1:0]  su_wr_idx,
    input  logic [CTRL_W-1:0] su_wr_ctrl,
    input  logic [IDX_W-1:0]  su_wr_next,
    input  logic              su_wr_last,
    input  logic [BANK_W-1:0] mode_sel,
    input  logic              step_done,
    output logic [CTRL_W-1:0] cfg_ctrl,
    output logic              cfg_valid
);

    logic [NUM_TMR-1:0] expire, pend;
    logic               start;
    logic [TMR_W-1:0]   grant;
    logic [BANK_W-1:0]  rd_bank;
    logic [IDX_W-1:0]   rd_idx;
    setup_word_t        rd_word, wr_word;

    assign wr_word = '{last: su_wr_last, nxt: su_wr_next, ctrl: su_wr_ctrl};

    for (genvar t = 0; t < NUM_TMR; t++) begin : g_tmr
        seq_timer #(.CNT_W(CNT_W)) u_tmr (
            .clk        (clk),
            .rst        (rst),
            .wr_en      (tmr_wr_en && (tmr_wr_sel == TMR_W'(t))),
            .wr_alt     (tmr_wr_alt),
            .wr_val     (tmr_wr_val),
            .rate_wr_en (rate_wr_en && (rate_wr_sel == TMR_W'(t))),
            .rate_val   (rate_wr_val),
            .expire     (expire[t])
        );
    end

    seq_setup_mem u_mem (
        .clk     (clk),
        .wr_en   (su_wr_en),
        .wr_bank (su_wr_bank),
        .wr_idx  (su_wr_idx),
        .wr_word (wr_word),
        .rd_bank (rd_bank),
        .rd_idx  (rd_idx),
        .rd_word (rd_word)
    );

    seq_core u_core (
        .clk       (clk),
        .rst       (rst),
        .expire    (expire),
        .mode_sel  (mode_sel),
        .step_done (step_done),
        .rd_word   (rd_word),
        .rd_bank   (rd_bank),
        .rd_idx    (rd_idx),
        .cfg_ctrl  (cfg_ctrl),
        .cfg_valid (cfg_valid),
        .pend      (pend),
        .start     (start),
        .grant     (grant)
    );

endmodule

// File: rtl/seq_checker.sv
module seq_checker
    import seq_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               cfg_valid,
    input logic [CTRL_W-1:0]  cfg_ctrl,
    input logic               step_done,
    input logic [NUM_TMR-1:0] expire,
    input logic [NUM_TMR-1:0] pend,
    input logic               start,
    input logic [TMR_W-1:0]   grant
);

    logic [NUM_TMR-1:0] below;
    always_comb below = (NUM_TMR'(1) << grant) - NUM_TMR'(1);

    p_idle_zero_r6: assert property (@(posedge clk) disable iff (rst)
        !cfg_valid |-> (cfg_ctrl == '0));

    p_step_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (cfg_valid && !step_done) |=> cfg_valid);

    p_start_from_pend_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(cfg_valid) |-> ($past(pend) != '0));

    p_expiry_kept_r8: assert property (@(posedge clk) disable iff (rst)
        (expire != '0) |=> ((pend & $past(expire)) == $past(expire)));

    p_lowest_first_r7: assert property (@(posedge clk) disable iff (rst)
        start |-> (pend[grant] && ((pend & below) == '0)));

    p_idle_stays_r9: assert property (@(posedge clk) disable iff (rst)
        (!cfg_valid && pend == '0) |=> !cfg_valid);

endmodule

bind timer_cfg_seq seq_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .cfg_valid (cfg_valid),
    .cfg_ctrl  (cfg_ctrl),
    .step_done (step_done),
    .expire    (expire),
    .pend      (pend),
    .start     (start),
    .grant     (grant)
);

// File: tb/tb_timer_cfg_seq.sv
module tb_timer_cfg_seq;
    import seq_pkg::*;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic              rst;
    logic              tmr_wr_en, tmr_wr_alt;
    logic [TMR_W-1:0]  tmr_wr_sel;
    logic [CNT_W-1:0]  tmr_wr_val;
    logic              rate_wr_en, rate_wr_val;
    logic [TMR_W-1:0]  rate_wr_sel;
    logic              su_wr_en, su_wr_last;
    logic [BANK_W-1:0] su_wr_bank;
    logic [IDX_W-1:0]  su_wr_idx, su_wr_next;
    logic [CTRL_W-1:0] su_wr_ctrl;
    logic [BANK_W-1:0] mode_sel;
    logic              step_done;
    logic [CTRL_W-1:0] cfg_ctrl;
    logic              cfg_valid;

    timer_cfg_seq dut (.*);

    // reference model state
    logic [CNT_W-1:0]   m_norm [NUM_TMR];
    logic [CNT_W-1:0]   m_alt  [NUM_TMR];
    logic [CNT_W-1:0]   m_cnt  [NUM_TMR];
    logic               m_rate [NUM_TMR];
    logic [NUM_TMR-1:0] m_pend;
    setup_word_t        m_mem [NUM_BANK][DEPTH];
    logic               m_run;
    logic [IDX_W-1:0]   m_idx;
    logic [BANK_W-1:0]  m_bank;

    int    n_chk = 0;
    int    n_fail = 0;
    bit    finished = 1'b0;
    string tag = "R1";

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic clear_inputs();
        tmr_wr_en = 0; tmr_wr_alt = 0; tmr_wr_sel = '0; tmr_wr_val = '0;
        rate_wr_en = 0; rate_wr_val = 0; rate_wr_sel = '0;
        su_wr_en = 0; su_wr_last = 0; su_wr_bank = '0; su_wr_idx = '0;
        su_wr_next = '0; su_wr_ctrl = '0;
    endtask

    task automatic model_reset();
        for (int i = 0; i < NUM_TMR; i++) begin
            m_norm[i] = '0; m_alt[i] = '0; m_cnt[i] = '0; m_rate[i] = 1'b0;
        end
        for (int b = 0; b < NUM_BANK; b++)
            for (int e = 0; e < DEPTH; e++) m_mem[b][e] = '0;
        m_pend = '0; m_run = 1'b0; m_idx = '0; m_bank = '0;
    endtask

    function automatic logic [CTRL_W-1:0] exp_ctrl();
        return m_run ? m_mem[m_bank][m_idx].ctrl : '0;
    endfunction

    // advance the model by one clock edge using the inputs now applied
    task automatic model_step();
        logic [NUM_TMR-1:0] ex;
        logic [NUM_TMR-1:0] clr;
        logic [CNT_W-1:0]   rl;
        setup_word_t        w;
        bit                 go;
        int                 pick;
        ex = '0;
        for (int i = 0; i < NUM_TMR; i++) begin
            rl = m_rate[i] ? m_alt[i] : m_norm[i];
            if (m_cnt[i] == 0 && rl != 0) begin
                ex[i] = 1'b1;
                m_cnt[i] = rl;
            end else if (m_cnt[i] != 0) begin
                m_cnt[i] = m_cnt[i] - 1;
            end
        end
        go = !m_run && (m_pend != 0);
        pick = 0;
        for (int i = 0; i < NUM_TMR; i++)
            if (m_pend[i]) begin pick = i; break; end
        clr = go ? (NUM_TMR'(1) << pick) : '0;
        w = m_mem[m_bank][m_idx];
        if (go) begin
            m_run = 1'b1; m_idx = IDX_W'(pick); m_bank = mode_sel;
        end else if (m_run && step_done) begin
            if (w.last) m_run = 1'b0;
            else        m_idx = w.nxt;
        end
        m_pend = (m_pend & ~clr) | ex;
        if (tmr_wr_en) begin
            if (tmr_wr_alt) m_alt[tmr_wr_sel] = tmr_wr_val;
            else            m_norm[tmr_wr_sel] = tmr_wr_val;
        end
        if (rate_wr_en) m_rate[rate_wr_sel] = rate_wr_val;
        if (su_wr_en)
            m_mem[su_wr_bank][su_wr_idx] = '{last: su_wr_last, nxt: su_wr_next, ctrl: su_wr_ctrl};
    endtask

    // called at a falling edge with this cycle's inputs applied
    task automatic tick();
        string req;
        req = m_run ? tag : "R6";
        check(cfg_valid == m_run, req, "cfg_valid", 32'(cfg_valid), 32'(m_run));
        check(cfg_ctrl == exp_ctrl(), req, "cfg_ctrl", 32'(cfg_ctrl), 32'(exp_ctrl()));
        model_step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr_tmr(input int t, input bit alt, input int val);
        tmr_wr_en = 1; tmr_wr_sel = TMR_W'(t); tmr_wr_alt = alt; tmr_wr_val = CNT_W'(val);
        tick();
        clear_inputs();
    endtask

    task automatic wr_rate(input int t, input bit v);
        rate_wr_en = 1; rate_wr_sel = TMR_W'(t); rate_wr_val = v;
        tick();
        clear_inputs();
    endtask

    task automatic run(input int n, input int done_pct, input bit mode_rand);
        for (int c = 0; c < n; c++) begin
            step_done = ($urandom_range(99) < done_pct);
            if (mode_rand) mode_sel = BANK_W'($urandom_range(NUM_BANK - 1));
            tick();
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1; clear_inputs(); mode_sel = '0; step_done = 0;
        model_reset();
        repeat (3) @(negedge clk);
        rst = 0;

        // R1: reset state, nothing armed so nothing starts
        check(cfg_valid == 1'b0, "R1", "reset cfg_valid", 32'(cfg_valid), 0);
        check(cfg_ctrl == '0, "R1", "reset cfg_ctrl", 32'(cfg_ctrl), 0);
        tag = "R1";
        run(20, 50, 1'b0);

        // load both banks: entries 0..3 are task heads, 4..7 end chains
        for (int b = 0; b < NUM_BANK; b++)
            for (int e = 0; e < DEPTH; e++) begin
                su_wr_en = 1; su_wr_bank = BANK_W'(b); su_wr_idx = IDX_W'(e);
                su_wr_ctrl = CTRL_W'($urandom) | CTRL_W'(1);
                su_wr_next = IDX_W'(4 + $urandom_range(3));
                su_wr_last = (e >= 4) ? 1'b1 : 1'(e == 2);
                tick();
                clear_inputs();
            end

        // R2: periodic expiry with the normal value
        tag = "R2";
        wr_tmr(1, 0, 5);
        run(60, 100, 1'b0);

        // R3: switch to the alternate rate
        tag = "R3";
        wr_tmr(1, 1, 2);
        wr_rate(1, 1);
        run(40, 100, 1'b0);
        wr_rate(1, 0);
        wr_tmr(1, 0, 0);
        run(10, 100, 1'b0);

        // R4: start entry and bank come from the timer and mode
        tag = "R4";
        mode_sel = 1'b1;
        wr_tmr(3, 0, 7);
        run(40, 100, 1'b0);
        wr_tmr(3, 0, 0);
        mode_sel = 1'b0;
        run(10, 100, 1'b0);

        // R7: timers 0 and 2 expire together ten cycles after these writes
        tag = "R7";
        wr_tmr(0, 0, 9);
        wr_tmr(2, 0, 8);
        run(40, 100, 1'b0);

        // R8: long stall so expiries pile up and merge
        tag = "R8";
        run(40, 0, 1'b0);
        run(30, 100, 1'b0);

        // R9: timers off, done toggles while idle
        tag = "R9";
        wr_tmr(0, 0, 0);
        wr_tmr(2, 0, 0);
        run(40, 50, 1'b0);

        // R10: mode changes while tasks run
        tag = "R10";
        wr_tmr(1, 0, 6);
        run(80, 40, 1'b1);

        // R5: random mix of writes, rates, mode and done
        tag = "R5";
        for (int c = 0; c < 1500; c++) begin
            if ($urandom_range(15) == 0) begin
                tmr_wr_en = 1; tmr_wr_sel = TMR_W'($urandom_range(NUM_TMR - 1));
                tmr_wr_alt = 1'($urandom_range(1)); tmr_wr_val = CNT_W'($urandom_range(20));
            end
            if ($urandom_range(15) == 0) begin
                rate_wr_en = 1; rate_wr_sel = TMR_W'($urandom_range(NUM_TMR - 1));
                rate_wr_val = 1'($urandom_range(1));
            end
            step_done = ($urandom_range(99) < 60);
            mode_sel = BANK_W'($urandom_range(NUM_BANK - 1));
            tick();
            clear_inputs();
        end

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule